// File: doc/BRIEF.md
# Output compare waveform generator

This block drives one compare output pin from an internal time base. The time base counts prescaled clock ticks and returns to zero when it reaches a programmed period or its own maximum value. Each rollover raises a period-match pulse. The 4-bit mode input sets what the pin does. It can stay low while the counter runs as a plain timer. It can be set, cleared or toggled when the count reaches compare value A. In dual-edge mode it forms a pulse that rises at A and falls at B. The dual-edge mode has a buffered variant. In that variant, new A/B values are first latched into shadow registers by a strobe, and they reach the comparators only at the next period boundary. This lets software change the pulse without glitches.

The width select input lets the single-edge and timer modes use a 32-bit count. The dual-edge modes always count in 16 bits, whatever the width select says.

Top module: `ocmp_wavegen`

## Requirements
- R1: After reset the count is 0, `cmp_out` is low and `prd_hit` is low.
- R2: With mode code 0000 the time base counts normally and `cmp_out` stays low.
- R3: On a tick where the count equals compare A, the pin changes as follows: mode 0001 drives it high, mode 0010 drives it low, and mode 0011 inverts it. The new level shows from the following cycle.
- R4: In mode 0100, `cmp_out` goes high on a tick where the count equals A. It goes low on a tick where the count equals B. When A equals B, low wins.
- R5: In modes 0100 and 0101 the count and the compares use only the low 16 bits. The count rolls over at 0xFFFF even when `wide` is 1.
- R6: In mode 0101, `upd_stb` latches `cmp_a`/`cmp_b` into shadow registers. The shadows are copied to the active compare values at the edge that ends a rollover cycle. A strobe in that same cycle takes effect only at the following boundary.
- R7: The time base advances once every 1, 4, 16 or 64 clocks, for `psc` = 00, 01, 10 and 11.
- R8: On a tick where the count is at or above `period`, or at its width maximum, `prd_hit` is high for that cycle and the count becomes 0 at the next edge.
- R9: Mode codes 0110 through 1111 hold `cmp_out` low.
- R10: While `en` is low the count and the prescaler are held at 0 and `cmp_out` is low.
- R11: In modes 0000 to 0011 with `wide` = 1, the count runs past 0xFFFF up to `period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable |
| mode | input | 4 | Output mode code |
| wide | input | 1 | Request 32-bit time base |
| psc | input | 2 | Prescale code |
| period | input | 32 | Period limit |
| cmp_a | input | 32 | Compare value A |
| cmp_b | input | 32 | Compare value B |
| upd_stb | input | 1 | Latch A/B into shadows (buffered mode) |
| cmp_out | output | 1 | Compare output pin |
| tb_count | output | 32 | Time base value |
| prd_hit | output | 1 | Rollover pulse |

## Verification
The hardest case to reach is the one where the update strobe arrives in the very cycle of a period boundary. There the active registers must take the old shadow contents while the shadow takes the new ones. The bench tracks the expected count and fires the strobe exactly on a predicted rollover cycle. Reaching the 16-bit maximum in dual-edge mode with 32-bit requested, and passing 0xFFFF in a wide single-edge mode, each needs a long directed run with a period above that limit. Random segments mix modes, prescalers, small periods and strobes so that many match and rollover coincidences occur.

// File: rtl/ocmp_wavegen.sv
module ocmp_wavegen #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   mode,
  input  logic         wide,
  input  logic [1:0]   psc,
  input  logic [W-1:0] period,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         upd_stb,
  output logic         cmp_out,
  output logic [W-1:0] tb_count,
  output logic         prd_hit
);
  localparam logic [W-1:0] MAX_H = {{(W-HW){1'b0}}, {HW{1'b1}}};

  logic [5:0]   pre_cnt;
  logic [6:0]   ratio;
  logic [W-1:0] sh_a, sh_b, act_a, act_b;

  wire dual = (mode == 4'd4) || (mode == 4'd5);
  wire w32  = wide && !dual;
  wire [W-1:0] maxv = w32 ? {W{1'b1}} : MAX_H;

  assign ratio = 7'd1 << {psc, 1'b0};
  wire [5:0] pre_lim = 6'(ratio - 7'd1);
  wire tick = en && (pre_cnt >= pre_lim);
  wire wrap = tick && (tb_count >= period || tb_count >= maxv);
  assign prd_hit = wrap;

  wire [W-1:0] ca = ((mode == 4'd5) ? act_a : cmp_a) & maxv;
  wire [W-1:0] cb = ((mode == 4'd5) ? act_b : cmp_b) & maxv;
  wire ma = tick && (tb_count == ca);
  wire mb = tick && (tb_count == cb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tb_count <= '0;
    end else if (!en) begin
      pre_cnt  <= '0;
      tb_count <= '0;
    end else begin
      pre_cnt <= tick ? 6'd0 : pre_cnt + 6'd1;
      if (tick) tb_count <= wrap ? '0 : tb_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; act_a <= '0; act_b <= '0;
    end else begin
      if (upd_stb) begin
        sh_a <= cmp_a;
        sh_b <= cmp_b;
      end
      if (wrap) begin
        act_a <= sh_a;
        act_b <= sh_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmp_out <= 1'b0;
    else if (!en || mode == 4'd0 || mode > 4'd5)
      cmp_out <= 1'b0;
    else begin
      unique case (mode)
        4'd1: if (ma) cmp_out <= 1'b1;
        4'd2: if (ma) cmp_out <= 1'b0;
        4'd3: if (ma) cmp_out <= ~cmp_out;
        default: begin
          if (mb)      cmp_out <= 1'b0;
          else if (ma) cmp_out <= 1'b1;
        end
      endcase
    end
  end
endmodule

module ocmp_wavegen_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [3:0]   mode,
  input logic [1:0]   psc,
  input logic         cmp_out,
  input logic [W-1:0] tb_count,
  input logic         prd_hit
);
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tb_count == '0) && !cmp_out); // R10
  AST_TIMER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |=> !cmp_out); // R2
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 4'd5) |=> !cmp_out); // R9
  AST_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prd_hit |=> (tb_count == '0)); // R8
  AST_DUAL_16: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode == 4'd4 || mode == 4'd5) && tb_count <= W'(32'hFFFF))
      |=> (tb_count <= W'(32'hFFFF))); // R5
  AST_PSC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && psc == 2'b00 && !prd_hit) |=> (tb_count == $past(tb_count) + 1'b1)); // R7
endmodule

bind ocmp_wavegen ocmp_wavegen_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .psc(psc),
  .cmp_out(cmp_out), .tb_count(tb_count), .prd_hit(prd_hit));

// File: tb/ocmp_wavegen_tb_top.sv
`timescale 1ns/1ps
module ocmp_wavegen_tb_top;
  logic clk = 0, rst_n = 0, en = 0, wide = 0, upd_stb = 0;
  logic [3:0] mode = 0;
  logic [1:0] psc = 0;
  logic [31:0] period = 0, cmp_a = 0, cmp_b = 0;
  logic cmp_out, prd_hit;
  logic [31:0] tb_count;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ocmp_wavegen dut_i (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .wide(wide),
    .psc(psc), .period(period), .cmp_a(cmp_a), .cmp_b(cmp_b), .upd_stb(upd_stb),
    .cmp_out(cmp_out), .tb_count(tb_count), .prd_hit(prd_hit));

  // reference state
  int unsigned m_pre;
  logic [31:0] m_cnt, m_sa, m_sb, m_aa, m_ab;
  logic m_out;

  function automatic bit is_dual(logic [3:0] md); return md == 4 || md == 5; endfunction
  function automatic logic [31:0] lim_max();
    return (wide && !is_dual(mode)) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction
  function automatic bit m_tick();
    int unsigned r;
    r = (psc == 0) ? 1 : (psc == 1) ? 4 : (psc == 2) ? 16 : 64;
    return en && (m_pre + 1 >= r);
  endfunction
  function automatic bit m_wrap();
    return m_tick() && (m_cnt >= period || m_cnt >= lim_max());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_out = 0; m_sa = 0; m_sb = 0; m_aa = 0; m_ab = 0;
    end else begin
      logic t, w, ma, mb;
      logic [31:0] a, b;
      t = m_tick(); w = m_wrap();
      a = ((mode == 5) ? m_aa : cmp_a) & lim_max();
      b = ((mode == 5) ? m_ab : cmp_b) & lim_max();
      ma = t && m_cnt == a; mb = t && m_cnt == b;
      if (!en || mode == 0 || mode > 5) m_out = 0;
      else if (mode == 1 && ma) m_out = 1;
      else if (mode == 2 && ma) m_out = 0;
      else if (mode == 3 && ma) m_out = ~m_out;
      else if (is_dual(mode)) begin
        if (mb) m_out = 0; else if (ma) m_out = 1;
      end
      if (w) begin m_aa = m_sa; m_ab = m_sb; end
      if (upd_stb) begin m_sa = cmp_a; m_sb = cmp_b; end
      if (!en) begin m_pre = 0; m_cnt = 0; end
      else if (t) begin m_pre = 0; m_cnt = w ? 0 : m_cnt + 1; end
      else m_pre = m_pre + 1;
    end
  end

  task automatic check(string tag);
    n_chk++;
    if (tb_count !== m_cnt || cmp_out !== m_out || prd_hit !== m_wrap()) begin
      n_bad++;
      $display("FAIL %s: cnt=%h out=%b hit=%b expected cnt=%h out=%b hit=%b",
        tag, tb_count, cmp_out, prd_hit, m_cnt, m_out, m_wrap());
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); check(tag);
    end
  endtask

  function automatic string mtag();
    case (mode)
      0: return "R2"; 1, 2, 3: return "R3"; 4: return "R4"; 5: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #200_000_000 ;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    run(3, "R10");
    // R2 timer only
    en = 1; mode = 0; period = 20; cmp_a = 5; run(50, "R2");
    // R3 single-edge set/clear/toggle
    mode = 1; cmp_a = 7; run(30, "R3");
    mode = 2; cmp_a = 12; run(30, "R3");
    mode = 3; cmp_a = 3; run(70, "R3");
    // R4 dual edge, also A==B low wins
    mode = 4; cmp_a = 4; cmp_b = 15; run(60, "R4");
    cmp_b = 4; run(45, "R4");
    // R7 prescalers
    mode = 3; cmp_a = 2; period = 6;
    for (int p = 0; p < 4; p++) begin psc = 2'(p); run(300, "R7"); end
    psc = 0;
    // R10 disable mid-run
    en = 0; run(10, "R10"); en = 1;
    // R6 buffered: strobe normally, then strobe in a rollover cycle
    mode = 5; period = 25; cmp_a = 3; cmp_b = 10; upd_stb = 1; run(1, "R6"); upd_stb = 0;
    run(60, "R6");
    while (!m_wrap()) run(1, "R6");
    cmp_a = 8; cmp_b = 20; upd_stb = 1; run(1, "R6"); upd_stb = 0;
    run(60, "R6");
    // R9 reserved codes
    for (int c = 6; c < 16; c++) begin mode = 4'(c); run(8, "R9"); end
    // R5 + R8: dual with wide requested rolls over at 0xFFFF
    en = 0; run(1, "R10"); en = 1;
    mode = 4; wide = 1; period = 32'h0003_0000; cmp_a = 100; cmp_b = 32'h0001_0005;
    run(65540, "R5");
    // R11 + R8: wide single-edge passes 0xFFFF up to period
    en = 0; run(1, "R10"); en = 1;
    mode = 3; period = 32'h0001_0008; cmp_a = 32'h0001_0002; run(65550, "R11");
    // random mix
    wide = 0;
    for (int s = 0; s < 60; s++) begin
      mode = 4'($urandom_range(0, 7)); psc = 2'($urandom_range(0, 1));
      period = $urandom_range(0, 40); cmp_a = $urandom_range(0, 45);
      cmp_b = $urandom_range(0, 45); en = ($urandom_range(0, 9) != 0);
      wide = $urandom_range(0, 1) == 1;
      for (int k = 0; k < 50; k++) begin
        upd_stb = ($urandom_range(0, 15) == 0);
        run(1, (!en) ? "R10" : mtag());
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule